// File: doc/BRIEF.md
# Conversion Result Byte Pair with Tear-Free Read Ordering

This block holds the most recent converter result and presents it to an 8-bit bus as a high byte and a low byte. A control input places the 10-bit value either against the top of the 16-bit pair (left alignment) or against its bottom (right alignment). The zero padding is always in the half of the pair away from the value.

Software reads the two bytes one at a time, so a new conversion could land between the two reads and leave software with a value stitched from two results. The block prevents this with a read-order lock. Which byte counts as the first read depends on the alignment: the low byte for right alignment, the high byte for left alignment. When software reads the first byte, the block copies the current result into a shadow. The other byte, the partner, then shows the shadow until software reads it. The first-read byte keeps tracking new results during that time. The same logic can sit behind every slot of a scan or multi-sample buffer.

Top module: `adc_result_rdlock`

## Requirements
- R1: After a synchronous reset, both byte outputs read 0x00 and no lock is held.
- R2: With right alignment (align_left=0), hi_q = {6'b0, d[9:8]} and lo_q = d[7:0].
- R3: With left alignment (align_left=1), hi_q = d[9:2] and lo_q = {d[1:0], 6'b0}.
- R4: While no lock is held, a result strobed on res_valid at a clock edge appears on both bytes right after that edge.
- R5: With right alignment, a pulse on rd_lo takes the lock. Until the lock is released, hi_q keeps the byte of the result that was visible when rd_lo was pulsed, while lo_q keeps following new results.
- R6: With left alignment, a pulse on rd_hi takes the lock. Until the lock is released, lo_q keeps the byte of the result that was visible when rd_hi was pulsed, while hi_q keeps following new results.
- R7: While the lock is held, reading the partner byte releases it: rd_hi with right alignment, rd_lo with left alignment. After that edge, the partner byte shows the latest result.
- R8: While no lock is held, reading the partner byte alone has no effect. Both outputs keep their values, and a later result still updates both bytes.
- R9: While the lock is held, a further read of the first byte does not re-capture the shadow. The partner byte keeps its original frozen value.
- R10: When a new result arrives at the same edge as the first-byte read, the partner byte freezes to the value from before that result. This is the value that software just read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe: res_data carries a new result |
| res_data | input | 10 | Conversion result |
| align_left | input | 1 | 1 = left alignment, 0 = right alignment |
| rd_hi | input | 1 | Bus read strobe for the high byte |
| rd_lo | input | 1 | Bus read strobe for the low byte |
| hi_q | output | 8 | High byte read value |
| lo_q | output | 8 | Low byte read value |

## Verification
The bench aims at the edges of the lock window and at what a wrong design would do there. A result landing in the same cycle as the first read catches a design that freezes the new value instead of the one software saw. A repeated first read while locked catches one that re-captures the shadow and tears the pair. A partner read with no lock held catches a design that wrongly takes the lock, or disturbs the outputs. Random traffic then mixes alignments, result strobes and both read strobes, and compares each cycle against a bench model. This exposes swapped padding, a wrong choice of first byte per alignment, and a lock that never releases.

// File: rtl/adc_rdlock_pkg.sv
package adc_rdlock_pkg;
  localparam int unsigned DEF_RES_W  = 10;
  localparam int unsigned DEF_BYTE_W = 8;

  typedef enum logic {
    ALIGN_RIGHT = 1'b0,
    ALIGN_LEFT  = 1'b1
  } align_e;
endpackage

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  output logic [RES_W-1:0] raw_q,
  output logic [RES_W-1:0] raw_nxt
);
  always_comb raw_nxt = res_valid ? res_data : raw_q;

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_nxt;
  end
endmodule

// File: rtl/adc_rd_lock.sv
module adc_rd_lock #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_first,
  input  logic             rd_second,
  input  logic [RES_W-1:0] raw_q,
  output logic             lock_q,
  output logic             lock_nxt,
  output logic [RES_W-1:0] shadow_nxt
);
  logic [RES_W-1:0] shadow_q;
  logic             take;

  // The lock is taken only from the idle state, so a repeated first read
  // keeps the original snapshot.
  always_comb begin
    take       = rd_first && !lock_q;
    shadow_nxt = take ? raw_q : shadow_q;
    if (lock_q) lock_nxt = !rd_second;
    else        lock_nxt = rd_first;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 1'b0;
      shadow_q <= '0;
    end else begin
      lock_q   <= lock_nxt;
      shadow_q <= shadow_nxt;
    end
  end

  // R7: reading the partner byte while locked frees the lock
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    lock_q && rd_second |=> !lock_q);

  // R5/R6: a first read from idle takes the lock
  a_r5_take: assert property (@(posedge clk) disable iff (rst)
    !lock_q && rd_first |=> lock_q);

  // R9: a repeated first read while locked keeps the snapshot
  a_r9_no_recapture: assert property (@(posedge clk) disable iff (rst)
    lock_q && rd_first |=> $stable(shadow_q));
endmodule

// File: rtl/adc_byte_pair_fmt.sv
module adc_byte_pair_fmt #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [RES_W-1:0]  data,
  input  logic              left,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo
);
  localparam int unsigned PAIR_W = 2 * BYTE_W;
  localparam int unsigned PAD    = PAIR_W - RES_W;

  logic [PAIR_W-1:0] word_r;
  logic [PAIR_W-1:0] word_l;
  logic [PAIR_W-1:0] word;

  generate
    if (PAD > 0) begin : g_pad
      assign word_r = {{PAD{1'b0}}, data};
      assign word_l = {data, {PAD{1'b0}}};
    end else begin : g_full
      assign word_r = data;
      assign word_l = data;
    end
  endgenerate

  always_comb begin
    word = left ? word_l : word_r;
    hi   = word[PAIR_W-1:BYTE_W];
    lo   = word[BYTE_W-1:0];
  end
endmodule

// File: rtl/adc_result_rdlock.sv
module adc_result_rdlock
  import adc_rdlock_pkg::*;
#(
  parameter int unsigned RES_W  = DEF_RES_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              align_left,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q
);
  localparam int unsigned PAD = 2 * BYTE_W - RES_W;

  align_e           align;
  logic             align_q;
  logic             rd_first, rd_second;
  logic [RES_W-1:0] raw_q, raw_nxt, shadow_nxt;
  logic             lock_q, lock_nxt;
  logic [BYTE_W-1:0] live_hi, live_lo, sh_hi, sh_lo;

  always_comb begin
    align     = align_e'(align_left);
    rd_first  = (align == ALIGN_LEFT) ? rd_hi : rd_lo;
    rd_second = (align == ALIGN_LEFT) ? rd_lo : rd_hi;
  end

  adc_rd_capture #(.RES_W(RES_W)) u_cap (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .raw_q(raw_q), .raw_nxt(raw_nxt)
  );

  adc_rd_lock #(.RES_W(RES_W)) u_lock (
    .clk(clk), .rst(rst), .rd_first(rd_first), .rd_second(rd_second),
    .raw_q(raw_q), .lock_q(lock_q), .lock_nxt(lock_nxt),
    .shadow_nxt(shadow_nxt)
  );

  adc_byte_pair_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt_live (
    .data(raw_nxt), .left(align_left), .hi(live_hi), .lo(live_lo)
  );

  adc_byte_pair_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt_shadow (
    .data(shadow_nxt), .left(align_left), .hi(sh_hi), .lo(sh_lo)
  );

  // Registered byte outputs: the partner side shows the snapshot while locked.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      lo_q    <= '0;
      align_q <= 1'b0;
    end else begin
      align_q <= align_left;
      hi_q    <= (lock_nxt && align == ALIGN_RIGHT) ? sh_hi : live_hi;
      lo_q    <= (lock_nxt && align == ALIGN_LEFT)  ? sh_lo : live_lo;
    end
  end

  // R5/R6: partner byte frozen across consecutive locked cycles
  a_r5_partner_frozen: assert property (@(posedge clk) disable iff (rst)
    lock_q && $past(lock_q) && (align_q == $past(align_q)) |->
      (align_q ? $stable(lo_q) : $stable(hi_q)));

  // R1: reset clears the outputs
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (hi_q == '0 && lo_q == '0));

  generate
    if (PAD > 0) begin : g_pad_chk
      // R3: padding bits of the low byte are zero in left alignment
      a_r3_pad_zero: assert property (@(posedge clk) disable iff (rst)
        align_q |-> lo_q[PAD-1:0] == '0);
      // R2: padding bits of the high byte are zero in right alignment
      a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
        !align_q |-> hi_q[BYTE_W-1:BYTE_W-PAD] == '0);
    end
  endgenerate
endmodule

// File: tb/sim_adc_result_rdlock.sv
module sim_adc_result_rdlock;
  logic       clk = 1'b0;
  logic       rst;
  logic       res_valid, align_left, rd_hi, rd_lo;
  logic [9:0] res_data;
  logic [7:0] hi_q, lo_q;

  int total = 0;
  int bad   = 0;
  logic [9:0] raw_m = '0, sh_m = '0;
  logic       lock_m = 1'b0;

  always #5 clk = ~clk;

  adc_result_rdlock u0 (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .align_left(align_left), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .hi_q(hi_q), .lo_q(lo_q)
  );

  function automatic logic [15:0] fmt(input logic [9:0] d, input logic al);
    return al ? {d, 6'b0} : {6'b0, d};
  endfunction

  task automatic check(input string req, input logic [7:0] eh, input logic [7:0] el);
    total++;
    if (hi_q !== eh || lo_q !== el) begin
      bad++;
      $display("FAIL %s: hi=%h lo=%h expected hi=%h lo=%h", req, hi_q, lo_q, eh, el);
    end
  endtask

  task automatic step(input logic v, input logic [9:0] d, input logic al,
                      input logic rh, input logic rl, input string req);
    logic first, second;
    logic [15:0] wl, ws;
    logic [7:0] eh, el;
    @(negedge clk);
    res_valid = v; res_data = d; align_left = al; rd_hi = rh; rd_lo = rl;
    first  = al ? rh : rl;
    second = al ? rl : rh;
    if (first && !lock_m) sh_m = raw_m;
    lock_m = lock_m ? !second : first;
    if (v) raw_m = d;
    wl = fmt(raw_m, al);
    ws = fmt(sh_m, al);
    eh = (lock_m && !al) ? ws[15:8] : wl[15:8];
    el = (lock_m && al)  ? ws[7:0]  : wl[7:0];
    @(posedge clk);
    #2;
    check(req, eh, el);
  endtask

  initial begin
    #(20000 * 10);
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst = 1; res_valid = 0; res_data = '0; align_left = 0; rd_hi = 0; rd_lo = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", 8'h00, 8'h00);
    @(negedge clk); rst = 0;

    // R2 / R3 / R4: formatting and unlocked update
    step(1, 10'h2A5, 0, 0, 0, "R2");
    step(0, 10'h000, 0, 0, 0, "R4");
    step(1, 10'h2A5, 1, 0, 0, "R3");
    step(1, 10'h3FF, 1, 0, 0, "R4");

    // R8: partner read with no lock (left: rd_lo), outputs unchanged
    step(0, 10'h000, 1, 0, 1, "R8");
    step(1, 10'h155, 1, 0, 0, "R8");

    // R6: left lock, new results update hi only
    step(0, 10'h000, 1, 1, 0, "R6");
    step(1, 10'h0C3, 1, 0, 0, "R6");
    step(1, 10'h3C0, 1, 0, 0, "R6");
    // R9: repeated first read keeps snapshot
    step(1, 10'h001, 1, 1, 0, "R9");
    // R7: release
    step(0, 10'h000, 1, 0, 1, "R7");

    // R10 with right alignment: result lands with first read
    step(1, 10'h1E7, 0, 0, 0, "R2");
    step(1, 10'h318, 0, 0, 1, "R10");
    step(1, 10'h0FF, 0, 0, 0, "R5");
    step(0, 10'h000, 0, 1, 0, "R7");
    // R8 right alignment: rd_hi alone
    step(0, 10'h000, 0, 1, 0, "R8");

    for (int i = 0; i < 2000; i++) begin
      logic v, al, rh, rl;
      logic [9:0] d;
      string tag;
      v  = ($urandom % 3) == 0;
      d  = 10'($urandom);
      al = ($urandom % 8) == 0 ? ~align_left : align_left;
      rh = ($urandom % 4) == 0;
      rl = ($urandom % 4) == 0;
      if (lock_m) tag = al ? "R6" : "R5";
      else        tag = al ? "R3" : "R2";
      step(v, d, al, rh, rl, tag);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule